// File: doc/BRIEF.md
# Width-Scalable Modular-Squaring Keystream Generator

The block produces a reproducible pseudo-random bit stream by squaring an internal state modulo a loaded modulus, one squaring for each advance request. After each squaring the new state becomes the next value to square, and a few low-order bits of it go out as a keystream word with a one-cycle valid strobe.

The operand width is chosen at load time in 64-bit slices, from one slice (64 bits) to eight slices (512 bits). The squaring runs in a radix-4 interleaved multiply-and-reduce datapath. Each cycle it takes two bits of the multiplier, most significant first, and reduces the partial result below the modulus by subtracting the modulus at most six times. Accumulator slices above the chosen width keep their value and never switch. The number of iterations and the number of keystream bits both depend on the chosen width.

A typical use loads a modulus, a seed and a width while the block is idle, then pulses the advance input once for each keystream word it needs. The caller must supply a seed that is numerically smaller than the modulus.

Top module: `qrg_top`

## Requirements
- R1: After a synchronous reset, `busy`, `ks_valid` and `ks_data` are all zero.
- R2: A load captures `width_sel`, `seed` and `modulus`. Every bit at or above the selected width is forced to zero, so junk in those bits never changes the keystream.
- R3: An advance accepted while idle raises `busy` on the next cycle. `busy` stays high for exactly w/2 cycles. `ks_valid` is high for exactly the one cycle after `busy` falls.
- R4: Each advance replaces the state S with S*S mod Q, where Q is the loaded modulus.
- R5: When `ks_valid` is high, `ks_data` holds the low floor(log2 w) bits of the new state, and every higher bit of `ks_data` is zero.
- R6: `width_sel` value n (0..7) selects the width w = 64*(n+1). This gives 6, 7, 7, 8, 8, 8, 8, 9 keystream bits for n = 0..7.
- R7: While `busy` is high, `load` and `step` have no effect. The modulus, width and state are unchanged, and no extra squaring is queued.
- R8: When `load` and `step` are both high on an idle cycle, the load takes effect and the advance is dropped.
- R9: Loading the same seed, modulus and width again reproduces the same keystream sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Capture seed, modulus and width (idle only) |
| step | input | 1 | Start one squaring (idle only) |
| width_sel | input | 3 | Width code n, width = 64*(n+1) |
| seed | input | 512 | Initial state, must be below the modulus |
| modulus | input | 512 | Modulus Q |
| busy | output | 1 | Squaring in progress |
| ks_valid | output | 1 | One-cycle strobe for a new keystream word |
| ks_data | output | 9 | Keystream bits, zero-extended |

## Verification
The keystream is tried at widths of one, two, three, five and eight slices. At each width the modulus has its top bit set, so the iteration count and the extraction count are both exercised at full length. The three-slice case has a width that is not a power of two, so it separates floor(log2 w) from a rounded-up count. The five-slice case catches a width decode that only handles powers of two. A seed and modulus carrying junk above the width must give the same words as the clean pair, which shows the masking works. Loads and advances injected while busy, and a load that coincides with an advance, show whether the control logic drops them rather than queuing them.

// File: rtl/qrg_pkg.sv
package qrg_pkg;
  localparam int DEF_SLICE_W = 64;
  localparam int DEF_NSLICE  = 8;

  // floor(log2(v)) for v >= 1
  function automatic int flog2(input int v);
    int k;
    k = 0;
    while ((64'd1 << (k + 1)) <= 64'(v)) k++;
    return k;
  endfunction
endpackage

// File: rtl/qrg_reduce.sv
module qrg_reduce #(
  parameter int W     = 512,
  parameter int MAX_K = 6
) (
  input  logic [W+2:0] val,
  input  logic [W-1:0] q,
  output logic [W+2:0] rem
);
  logic [W+2:0] kq [MAX_K+1];
  logic [MAX_K:0] ge;

  genvar k;
  generate
    for (k = 0; k <= MAX_K; k++) begin : g_mult
      assign kq[k] = {3'b000, q} * (W+3)'(k);
      assign ge[k] = (val >= kq[k]);
    end
  endgenerate

  // pick the largest multiple of q not above val
  always_comb begin
    rem = val;
    for (int i = 1; i <= MAX_K; i++)
      if (ge[i]) rem = val - kq[i];
  end
endmodule

// File: rtl/qrg_mac.sv
module qrg_mac #(
  parameter int SLICE_W = 64,
  parameter int NSLICE  = 8,
  localparam int W = SLICE_W * NSLICE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              en,
  input  logic [1:0]        digit,
  input  logic [W-1:0]      x,
  input  logic [W-1:0]      q,
  input  logic [NSLICE-1:0] slice_en,
  output logic [W-1:0]      acc,
  output logic [W-1:0]      nxt
);
  logic [W+2:0] sum;
  logic [W+2:0] rem;

  always_comb begin
    sum = {1'b0, acc, 2'b00}
        + ({3'b000, x} & {(W+3){digit[0]}})
        + ({2'b00, x, 1'b0} & {(W+3){digit[1]}});
  end

  qrg_reduce #(.W(W), .MAX_K(6)) u_red (
    .val(sum),
    .q  (q),
    .rem(rem)
  );

  assign nxt = rem[W-1:0];

  genvar s;
  generate
    for (s = 0; s < NSLICE; s++) begin : g_slice
      always_ff @(posedge clk) begin
        if (rst || clr)
          acc[s*SLICE_W +: SLICE_W] <= '0;
        else if (en && slice_en[s])
          acc[s*SLICE_W +: SLICE_W] <= nxt[s*SLICE_W +: SLICE_W];
      end

      // R2
      idle_slice_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !slice_en[s] |-> (acc[s*SLICE_W +: SLICE_W] == '0));
    end
  endgenerate

  // R4
  rem_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    en |-> (rem[W+2:W] == 3'b000));
endmodule

// File: rtl/qrg_top.sv
module qrg_top
  import qrg_pkg::*;
#(
  parameter int SLICE_W = DEF_SLICE_W,
  parameter int NSLICE  = DEF_NSLICE,
  localparam int W     = SLICE_W * NSLICE,
  localparam int SEL_W = $clog2(NSLICE),
  localparam int KS_W  = $clog2(W),
  localparam int CNT_W = $clog2(W / 2)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [SEL_W-1:0] width_sel,
  input  logic [W-1:0]     seed,
  input  logic [W-1:0]     modulus,
  output logic             busy,
  output logic             ks_valid,
  output logic [KS_W-1:0]  ks_data
);
  logic [W-1:0]      state_r, q_r, acc, nxt;
  logic [SEL_W-1:0]  wsel_r;
  logic [CNT_W-1:0]  cnt_r;
  logic [NSLICE-1:0] slice_en;
  logic [1:0]        digit;
  logic              clr;

  function automatic logic [W-1:0] width_mask(input logic [SEL_W-1:0] sel);
    logic [W-1:0] m;
    for (int i = 0; i < NSLICE; i++)
      m[i*SLICE_W +: SLICE_W] = (i <= int'(sel)) ? '1 : '0;
    return m;
  endfunction

  function automatic logic [KS_W-1:0] ks_mask(input logic [SEL_W-1:0] sel);
    int k;
    k = flog2((int'(sel) + 1) * SLICE_W);
    return KS_W'((64'd1 << k) - 64'd1);
  endfunction

  function automatic logic [CNT_W-1:0] last_iter(input logic [SEL_W-1:0] sel);
    return CNT_W'((int'(sel) + 1) * SLICE_W / 2 - 1);
  endfunction

  genvar s;
  generate
    for (s = 0; s < NSLICE; s++) begin : g_en
      assign slice_en[s] = (s <= int'(wsel_r));
    end
  endgenerate

  assign digit = busy ? state_r[{cnt_r, 1'b0} +: 2] : 2'b00;
  assign clr   = !busy && (load || step);

  qrg_mac #(.SLICE_W(SLICE_W), .NSLICE(NSLICE)) u_mac (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .en      (busy),
    .digit   (digit),
    .x       (state_r),
    .q       (q_r),
    .slice_en(slice_en),
    .acc     (acc),
    .nxt     (nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_r  <= '0;
      q_r      <= '0;
      wsel_r   <= '0;
      cnt_r    <= '0;
      busy     <= 1'b0;
      ks_valid <= 1'b0;
      ks_data  <= '0;
    end else begin
      ks_valid <= 1'b0;
      if (!busy) begin
        if (load) begin
          wsel_r  <= width_sel;
          state_r <= seed & width_mask(width_sel);
          q_r     <= modulus & width_mask(width_sel);
        end else if (step) begin
          busy  <= 1'b1;
          cnt_r <= last_iter(wsel_r);
        end
      end else if (cnt_r == '0) begin
        busy     <= 1'b0;
        state_r  <= nxt;
        ks_valid <= 1'b1;
        ks_data  <= nxt[KS_W-1:0] & ks_mask(wsel_r);
      end else begin
        cnt_r <= cnt_r - 1'b1;
      end
    end
  end

  // R3
  ks_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ks_valid |=> !ks_valid);
  // R3
  done_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ks_valid);
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(q_r) && $stable(wsel_r)));
  // R4
  acc_below_mod_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && q_r != '0) |-> (acc < q_r));
  // R2
  state_masked_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_r & ~width_mask(wsel_r)) == '0));
endmodule

// File: tb/tb_qrg_top.sv
module tb_qrg_top;
  localparam int W    = 512;
  localparam int KS_W = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0, step = 1'b0;
  logic [2:0] width_sel = '0;
  logic [W-1:0] seed = '0, modulus = '0;
  logic busy, ks_valid;
  logic [KS_W-1:0] ks_data;

  int n_chk = 0, n_bad = 0, cyc = 0;

  qrg_top dut (
    .clk(clk), .rst(rst), .load(load), .step(step), .width_sel(width_sel),
    .seed(seed), .modulus(modulus), .busy(busy), .ks_valid(ks_valid), .ks_data(ks_data)
  );

  always #10 clk = ~clk;

  function automatic logic [W-1:0] wmask(input int sel);
    logic [W-1:0] m;
    m = '0;
    for (int i = 0; i < 64 * (sel + 1); i++) m[i] = 1'b1;
    return m;
  endfunction

  function automatic int kbits(input int sel);
    int w, k;
    w = 64 * (sel + 1);
    k = 0;
    while ((1 << (k + 1)) <= w) k++;
    return k;
  endfunction

  function automatic logic [W-1:0] modsq(input logic [W-1:0] s, input logic [W-1:0] q);
    logic [2*W-1:0] p, r;
    p = {{W{1'b0}}, s} * {{W{1'b0}}, s};
    r = p % {{W{1'b0}}, q};
    return r[W-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [W-1:0] m_s, m_q, sq_t;
  int m_sel, m_cnt;
  logic m_busy, m_valid;
  logic [KS_W-1:0] m_ks;

  always @(posedge clk) begin
    if (rst) begin
      m_busy = 0; m_valid = 0; m_ks = '0; m_cnt = 0; m_sel = 0; m_s = '0; m_q = '0;
    end else begin
      m_valid = 0;
      if (!m_busy) begin
        if (load) begin
          m_sel = int'(width_sel);
          m_s = seed & wmask(m_sel);
          m_q = modulus & wmask(m_sel);
        end else if (step) begin
          m_busy = 1;
          m_cnt = 32 * (m_sel + 1);
        end
      end else begin
        if (m_cnt == 1) begin
          sq_t = modsq(m_s, m_q);
          m_s = sq_t;
          m_busy = 0;
          m_valid = 1;
          m_ks = KS_W'(sq_t & ((W'(1) << kbits(m_sel)) - W'(1)));
        end
        m_cnt--;
      end
    end
  end

  // per-clock comparison
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      check(busy == m_busy, "R3 busy", W'(busy), W'(m_busy));
      check(ks_valid == m_valid, "R3 ks_valid", W'(ks_valid), W'(m_valid));
      if (m_valid) check(ks_data == m_ks, "R4 R5 ks_data", W'(ks_data), W'(m_ks));
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  function automatic logic [W-1:0] mk_mod(input int sel);
    logic [W-1:0] m;
    m = {8{64'hC3A5_96E1_7B2D_4F09}} & wmask(sel);
    m[64 * (sel + 1) - 1] = 1'b1;
    m[0] = 1'b1;
    return m;
  endfunction

  function automatic logic [W-1:0] mk_seed(input int sel, input logic [63:0] pat);
    return {8{pat}} & (wmask(sel) >> 1);
  endfunction

  task automatic do_load(input int sel, input logic [W-1:0] sd, input logic [W-1:0] md);
    @(negedge clk);
    load = 1; width_sel = 3'(sel); seed = sd; modulus = md;
    @(negedge clk);
    load = 0;
  endtask

  task automatic do_step(input int sel, output logic [KS_W-1:0] ks);
    int len;
    @(negedge clk);
    step = 1;
    @(negedge clk);
    step = 0;
    len = 0;
    while (busy && len < 1000) begin len++; @(negedge clk); end
    check(len == 32 * (sel + 1), "R6 busy length", W'(len), W'(32 * (sel + 1)));
    check(ks_valid == 1'b1, "R3 strobe after busy", W'(ks_valid), W'(1));
    check((ks_data >> kbits(sel)) == 0, "R5 upper zero", W'(ks_data), W'(0));
    ks = ks_data;
  endtask

  initial begin
    logic [KS_W-1:0] ref_ks [3];
    logic [KS_W-1:0] k;
    logic [W-1:0] sa, qa;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check(busy == 0 && ks_valid == 0 && ks_data == 0, "R1 reset outputs",
          W'({busy, ks_valid, ks_data}), W'(0));

    // one slice, reference run
    sa = mk_seed(0, 64'h1D2C_3B4A_5968_7786);
    qa = mk_mod(0);
    do_load(0, sa, qa);
    for (int i = 0; i < 3; i++) begin do_step(0, k); ref_ks[i] = k; end

    // R9 reload reproduces
    do_load(0, sa, qa);
    for (int i = 0; i < 3; i++) begin
      do_step(0, k);
      check(k == ref_ks[i], "R9 reproducible", W'(k), W'(ref_ks[i]));
    end

    // R2 junk above width ignored
    do_load(0, sa | ~wmask(0), qa | ~wmask(0));
    for (int i = 0; i < 3; i++) begin
      do_step(0, k);
      check(k == ref_ks[i], "R2 masked load", W'(k), W'(ref_ks[i]));
    end

    // several widths (R6)
    do_load(1, mk_seed(1, 64'h0F1E_2D3C_4B5A_6978), mk_mod(1));
    repeat (3) do_step(1, k);
    do_load(2, mk_seed(2, 64'h7766_5544_3322_1100), mk_mod(2));
    repeat (3) do_step(2, k);
    do_load(4, mk_seed(4, 64'h0123_4567_89AB_CDEF), mk_mod(4));
    repeat (2) do_step(4, k);
    do_load(7, mk_seed(7, 64'h5A5A_3C3C_0F0F_9696), mk_mod(7));
    repeat (2) do_step(7, k);

    // R7 load/step during busy ignored
    do_load(0, sa, qa);
    @(negedge clk); step = 1;
    @(negedge clk); step = 0;
    repeat (5) @(negedge clk);
    load = 1; step = 1; width_sel = 3'd3; seed = mk_seed(3, 64'h1111_2222_3333_4444); modulus = mk_mod(3);
    @(negedge clk); load = 0; step = 0;
    while (busy) @(negedge clk);
    check(ks_data == ref_ks[0], "R7 ignored while busy", W'(ks_data), W'(ref_ks[0]));
    @(negedge clk);
    check(busy == 0, "R7 no queued step", W'(busy), W'(0));

    // R8 load wins over step
    @(negedge clk);
    load = 1; step = 1; width_sel = 3'd0; seed = sa; modulus = qa;
    @(negedge clk); load = 0; step = 0;
    check(busy == 0, "R8 step dropped", W'(busy), W'(0));
    do_step(0, k);
    check(k == ref_ks[0], "R8 load applied", W'(k), W'(ref_ks[0]));

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule